// File: doc/BRIEF.md
# Address-Folded SECDED Memory ECC

This block protects a 128-bit memory word with a 9-bit single-error-correct, double-error-detect code whose coverage includes the word address as well as the data. The address bits are never stored. On a write the block folds the target address into the code, and on a read it folds in the address the read was issued to. When a word is returned from a location other than the one it was written to, the mismatch then shows up in the syndrome and is not mistaken for good data.

The write side is purely combinational: the memory controller presents the write data and address and stores the check bits that come back beside the data. The read side takes the raw data, the stored check bits and the read address, and classifies the access. It fixes a single flipped data bit, absorbs a flipped check bit, flags double errors and address errors, and presents the outcome one clock later with the failing address. An enable input turns checking off so that raw data passes through unflagged.

Top module: `secded_addr_ecc`

## Requirements
- R1: `wr_chk[7:0]` bit b is the XOR of every data and address bit whose code position has bit b set. Code positions are the integers 1..255 that are not powers of two, taken in ascending order: data bits 0..127 first, then address bits 0..ADDR_W-1. `wr_chk[8]` is the XOR of all data bits, all address bits and `wr_chk[7:0]`.
- R2: A read presented with `rd_valid` high in one cycle yields `rsp_valid` high in the following cycle and in no other. `rsp_valid` stays low after a cycle with `rd_valid` low.
- R3: A read whose data and check bits match what was written to the same address reports `rsp_kind` 2'b00 (clean), returns the data unchanged and drives `rsp_err_addr` to zero. The kind encoding is 00 clean, 01 corrected, 10 double error, 11 address error.
- R4: A read with exactly one flipped data bit reports kind 2'b01, returns the originally written data and sets `rsp_err_addr` to the read address.
- R5: A read with exactly one flipped check bit, any of the nine, reports kind 2'b01 and returns the data unchanged.
- R6: A read with two flipped bits among data and check bits reports kind 2'b10 and returns the read data without modification.
- R7: A read whose address differs from the written address in exactly one bit reports kind 2'b11, returns the read data without modification and sets `rsp_err_addr` to the read address.
- R8: With `ecc_en` low, a read reports kind 2'b00, returns the raw read data and drives `rsp_err_addr` to zero, whatever the check bits hold.
- R9: During and right after reset, `rsp_valid` is low, `rsp_kind` is 2'b00, and `rsp_data` and `rsp_err_addr` are zero.
- R10: A read whose address differs from the written address in exactly two bits reports kind 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Checking enable for reads |
| wr_data | input | 128 | Data being written |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_chk | output | 9 | Check bits to store with the write |
| rd_valid | input | 1 | Read data and check bits are present |
| rd_addr | input | ADDR_W | Word address the read was issued to |
| rd_data | input | 128 | Raw data from the array |
| rd_chk | input | 9 | Stored check bits from the array |
| rsp_valid | output | 1 | Read result valid |
| rsp_data | output | 128 | Corrected or passed-through data |
| rsp_kind | output | 2 | Outcome: 00 clean, 01 corrected, 10 double, 11 address |
| rsp_err_addr | output | ADDR_W | Read address of a flagged read, else zero |

## Verification
The bench flips data bits at both ends and in the middle of the word. A decoder with the position map off by one would correct the wrong bit or call a data error an address error. It flips each class of check bit, including the overall parity bit, and a design that mishandles a zero or power-of-two syndrome would alter the data or report a double error. It reads back with one and with two address bits changed: a design that left the address out of the code would report those reads clean, and one that ignored the parity bit would confuse the two cases. Reads with checking disabled and corrupted data confirm that nothing is flagged or altered, and gaps between reads confirm no stray responses.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W     = 128;
    localparam int HAM_W      = 8;
    localparam int CHK_W      = HAM_W + 1;
    localparam int CODE_SLOTS = (1 << HAM_W) - 1 - HAM_W;

    typedef enum logic [1:0] {
        RD_CLEAN  = 2'b00,
        RD_FIXED  = 2'b01,
        RD_DOUBLE = 2'b10,
        RD_ADDR   = 2'b11
    } rd_kind_e;

    typedef struct packed {
        logic [HAM_W-1:0] syn;
        logic             odd;
    } syn_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rd_kind_e          kind;
    } rd_out_t;

    // Code position of the idx-th covered bit: the (idx+1)-th integer that
    // is not a power of two. Each power of two not above the running value
    // pushes it up by one.
    function automatic int unsigned code_pos(int unsigned idx);
        int unsigned p;
        p = idx + 1;
        for (int j = 0; j < HAM_W; j++) begin
            if (p >= (32'd1 << j)) p = p + 1;
        end
        return p;
    endfunction

    function automatic logic is_pow2(logic [HAM_W-1:0] v);
        return (v != '0) && ((v & (v - 1'b1)) == '0);
    endfunction

endpackage

// File: rtl/secded_parity.sv
module secded_parity
    import secded_pkg::*;
#(
    parameter int W = 144
) (
    input  logic [W-1:0]     word,
    output logic [CHK_W-1:0] chk
);

    function automatic logic [W-1:0] slot_mask(int unsigned b);
        logic [W-1:0] m;
        int unsigned  p;
        m = '0;
        for (int k = 0; k < W; k++) begin
            p    = code_pos(k);
            m[k] = p[b];
        end
        return m;
    endfunction

    logic [HAM_W-1:0] ham;

    for (genvar b = 0; b < HAM_W; b++) begin : g_ham
        localparam logic [W-1:0] MASK = slot_mask(b);
        assign ham[b] = ^(word & MASK);
    end

    assign chk = {(^word) ^ (^ham), ham};

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
#(
    parameter int W = 144
) (
    input  logic [W-1:0]     word,
    input  logic [CHK_W-1:0] stored,
    output syn_t             s
);

    logic [CHK_W-1:0] fresh;

    secded_parity #(.W(W)) u_recalc (
        .word (word),
        .chk  (fresh)
    );

    assign s.syn = fresh[HAM_W-1:0] ^ stored[HAM_W-1:0];
    assign s.odd = (^word) ^ (^stored);

endmodule

// File: rtl/secded_correct.sv
module secded_correct
    import secded_pkg::*;
(
    input  logic              en,
    input  syn_t              s,
    input  logic [DATA_W-1:0] raw,
    output rd_out_t           res
);

    logic [DATA_W-1:0] hit;
    logic              data_hit;
    logic              syn_zero;
    logic              syn_chk;

    for (genvar k = 0; k < DATA_W; k++) begin : g_hit
        localparam int unsigned POS = code_pos(k);
        assign hit[k] = (s.syn == POS[HAM_W-1:0]);
    end

    assign data_hit = |hit;
    assign syn_zero = (s.syn == '0);
    assign syn_chk  = is_pow2(s.syn);

    always_comb begin
        res.data = raw;
        res.kind = RD_CLEAN;
        if (en) begin
            if (!s.odd) begin
                res.kind = syn_zero ? RD_CLEAN : RD_DOUBLE;
            end else if (syn_zero || syn_chk) begin
                res.kind = RD_FIXED;
            end else if (data_hit) begin
                res.kind = RD_FIXED;
                res.data = raw ^ hit;
            end else begin
                res.kind = RD_ADDR;
            end
        end
    end

endmodule

// File: rtl/secded_addr_ecc.sv
module secded_addr_ecc
    import secded_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ecc_en,
    input  logic [127:0]      wr_data,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic [8:0]        wr_chk,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [127:0]      rd_data,
    input  logic [8:0]        rd_chk,
    output logic              rsp_valid,
    output logic [127:0]      rsp_data,
    output logic [1:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_err_addr
);

    localparam int WORD_W = DATA_W + ADDR_W;

    if (WORD_W > CODE_SLOTS) begin : g_too_wide
        $error("address too wide for the code positions");
    end

    syn_t              rd_syn;
    rd_out_t           rd_res;
    rd_out_t           res_q;
    logic [ADDR_W-1:0] err_addr_q;
    logic              valid_q;

    secded_parity #(.W(WORD_W)) u_wr_enc (
        .word ({wr_addr, wr_data}),
        .chk  (wr_chk)
    );

    secded_syndrome #(.W(WORD_W)) u_rd_syn (
        .word   ({rd_addr, rd_data}),
        .stored (rd_chk),
        .s      (rd_syn)
    );

    secded_correct u_rd_fix (
        .en  (ecc_en),
        .s   (rd_syn),
        .raw (rd_data),
        .res (rd_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= 1'b0;
            res_q      <= '{data: '0, kind: RD_CLEAN};
            err_addr_q <= '0;
        end else begin
            valid_q <= rd_valid;
            if (rd_valid) begin
                res_q      <= rd_res;
                err_addr_q <= (rd_res.kind == RD_CLEAN) ? '0 : rd_addr;
            end
        end
    end

    assign rsp_valid    = valid_q;
    assign rsp_data     = res_q.data;
    assign rsp_kind     = res_q.kind;
    assign rsp_err_addr = err_addr_q;

endmodule

// File: rtl/secded_addr_ecc_chk.sv
module secded_addr_ecc_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ecc_en,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [127:0]      rd_data,
    input logic              rsp_valid,
    input logic [127:0]      rsp_data,
    input logic [1:0]        rsp_kind,
    input logic [ADDR_W-1:0] rsp_err_addr
);

    AST_RSP_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> rsp_valid); // R2

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> !rsp_valid); // R2

    AST_CLEAN_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 2'b00) |-> (rsp_err_addr == '0)); // R3

    AST_FIX_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (rsp_kind != 2'b01 || $countones(rsp_data ^ $past(rd_data)) <= 1)); // R4

    AST_UNFIXED_RAW: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> (rsp_kind == 2'b01 || rsp_data == $past(rd_data))); // R6

    AST_FLAG_ADDR: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && ecc_en) |=> (rsp_kind == 2'b00 || rsp_err_addr == $past(rd_addr))); // R7

    AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !ecc_en) |=> (rsp_kind == 2'b00 && rsp_data == $past(rd_data)
                                   && rsp_err_addr == '0)); // R8

endmodule

bind secded_addr_ecc secded_addr_ecc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ecc_en       (ecc_en),
    .rd_valid     (rd_valid),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .rsp_valid    (rsp_valid),
    .rsp_data     (rsp_data),
    .rsp_kind     (rsp_kind),
    .rsp_err_addr (rsp_err_addr)
);

// File: tb/tb_secded_addr_ecc.sv
`timescale 1ns/1ps
module tb_secded_addr_ecc;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ecc_en = 1'b1;
    logic [127:0]  wr_data = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [8:0]    wr_chk;
    logic          rd_valid = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [127:0]  rd_data = '0;
    logic [8:0]    rd_chk = '0;
    logic          rsp_valid;
    logic [127:0]  rsp_data;
    logic [1:0]    rsp_kind;
    logic [AW-1:0] rsp_err_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [127:0]  data;
        logic [1:0]    kind;
        logic [AW-1:0] addr;
        int            due;
        string         req;
    } exp_t;

    exp_t sb[$];

    secded_addr_ecc #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en),
        .wr_data(wr_data), .wr_addr(wr_addr), .wr_chk(wr_chk),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_chk(rd_chk),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_kind(rsp_kind),
        .rsp_err_addr(rsp_err_addr)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Reference code: XOR of the positions of all set bits, plus total parity.
    function automatic logic [8:0] ref_chk(logic [127:0] d, logic [AW-1:0] a);
        logic [7:0] s;
        int         k;
        s = '0;
        k = 0;
        for (int q = 1; q < 256; q++) begin
            if ((q & (q - 1)) != 0) begin
                if (k < 128) begin
                    if (d[k]) s = s ^ q[7:0];
                end else if (k < 128 + AW) begin
                    if (a[k-128]) s = s ^ q[7:0];
                end
                k++;
            end
        end
        return {(^d) ^ (^a) ^ (^s), s};
    endfunction

    task automatic wr_test(input logic [127:0] d, input logic [AW-1:0] a);
        logic [8:0] exp;
        @(negedge clk);
        wr_data = d;
        wr_addr = a;
        #1;
        exp = ref_chk(d, a);
        checks++;
        if (wr_chk !== exp) begin
            errors++;
            $display("FAIL R1 wr_chk actual=%h expected=%h", wr_chk, exp);
        end
    endtask

    task automatic rd(input logic [127:0] d, input logic [AW-1:0] waddr,
                      input logic [127:0] dflip, input logic [8:0] cflip,
                      input logic [AW-1:0] raddr, input bit en,
                      input logic [1:0] kind, input bit want_orig, input string req);
        exp_t e;
        @(negedge clk);
        ecc_en   = en;
        rd_valid = 1'b1;
        rd_addr  = raddr;
        rd_data  = d ^ dflip;
        rd_chk   = ref_chk(d, waddr) ^ cflip;
        e.data   = want_orig ? d : (d ^ dflip);
        e.kind   = kind;
        e.addr   = (kind == 2'b00) ? '0 : raddr;
        e.due    = cyc + 1;
        e.req    = req;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R2 response with nothing outstanding actual=1 expected=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_kind !== e.kind || rsp_data !== e.data ||
                    rsp_err_addr !== e.addr || cyc != e.due) begin
                    errors++;
                    $display("FAIL %s kind=%b data=%h addr=%h cyc=%0d expected kind=%b data=%h addr=%h cyc=%0d",
                             e.req, rsp_kind, rsp_data, rsp_err_addr, cyc,
                             e.kind, e.data, e.addr, e.due);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa, pb, pc;
        pa = {4{32'hC3A5_5A3C}};
        pb = 128'h0F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0;
        pc = {64'h1, 64'h8000_0000_0000_0000};

        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0 || rsp_kind !== 2'b00 || rsp_data !== '0 || rsp_err_addr !== '0) begin
            errors++;
            $display("FAIL R9 reset outputs actual=%b/%b/%h/%h expected=0/00/0/0",
                     rsp_valid, rsp_kind, rsp_data, rsp_err_addr);
        end
        rst = 1'b0;

        // R1: check bit generation
        wr_test('0, '0);
        wr_test('1, '1);
        wr_test(pa, 16'h1234);
        wr_test(pb, 16'h8001);
        wr_test(pc, 16'h0000);
        wr_test('0, 16'h4000);

        // R3: clean reads
        rd(pa, 16'h1234, '0, '0, 16'h1234, 1, 2'b00, 1, "R3 clean");
        rd('1, 16'hFFFF, '0, '0, 16'hFFFF, 1, 2'b00, 1, "R3 clean ones");
        // R4: single data bit
        rd(pb, 16'h0042, 128'h1, '0, 16'h0042, 1, 2'b01, 1, "R4 bit0");
        rd(pb, 16'h0042, 128'h1 << 77, '0, 16'h0042, 1, 2'b01, 1, "R4 bit77");
        rd(pa, 16'hBEEF, 128'h1 << 127, '0, 16'hBEEF, 1, 2'b01, 1, "R4 bit127");
        // R5: single check bit
        rd(pc, 16'h0101, '0, 9'h001, 16'h0101, 1, 2'b01, 1, "R5 chk0");
        rd(pc, 16'h0101, '0, 9'h020, 16'h0101, 1, 2'b01, 1, "R5 chk5");
        rd(pc, 16'h0101, '0, 9'h100, 16'h0101, 1, 2'b01, 1, "R5 chk8");
        // R6: double errors
        rd(pa, 16'h0007, (128'h1 << 3) | (128'h1 << 100), '0, 16'h0007, 1, 2'b10, 0, "R6 two data");
        rd(pb, 16'h0007, 128'h1 << 10, 9'h004, 16'h0007, 1, 2'b10, 0, "R6 data+chk");
        // R7: single address bit mismatch
        rd(pa, 16'h2000, '0, '0, 16'h2001, 1, 2'b11, 0, "R7 addr bit0");
        rd(pb, 16'h2000, '0, '0, 16'hA000, 1, 2'b11, 0, "R7 addr bit15");
        // R10: two address bits
        rd(pc, 16'h00F0, '0, '0, 16'h00F6, 1, 2'b10, 0, "R10 addr two bits");
        // R8: checking disabled
        rd(pa, 16'h0033, 128'h1 << 40, 9'h003, 16'h0033, 0, 2'b00, 0, "R8 disabled data");
        rd(pb, 16'h0033, '0, '0, 16'h0032, 0, 2'b00, 0, "R8 disabled addr");

        // R2: no response after an idle cycle
        idle(2);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle rsp_valid actual=%b expected=0", rsp_valid);
        end
        rd(pb, 16'h5555, '0, '0, 16'h5555, 1, 2'b00, 1, "R2 spaced read");
        idle(3);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses actual=%0d expected=0", sb.size());
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule